// File: doc/BRIEF.md
# Secondary Interrupt Controller with Passthrough

This block gathers 32 level-sensitive interrupt requests in front of a primary interrupt controller. Every clock it captures the request lines into a raw level register. It masks that register with a software-written enable register and ORs the surviving bits onto a single combined line, the top output line. A window of ten lines, 21 through 30, can also be routed one by one onto output lines of the same index. This lets those sources reach the primary controller directly, whatever their enable bit holds.

Software reaches the block through a word-indexed register window of 4 KB. The index is `req_addr[11:2]`, and all other address bits are ignored. Both the enable mask and the routing mask are changed only through separate set and clear indices, so a write never has to read, modify and write back. A request is a single-beat valid/ready transfer. `req_ready` is tied high, so there is never back-pressure and every cycle with `req_valid` high is accepted. Each accepted read returns exactly one `rsp_valid` pulse in the next cycle. The response path has no ready, and the consumer must take the data in that cycle.

Top module: `irqx_ctrl`

## Requirements
- R1: The raw level register takes the value of `irq_in` at every rising clock edge. Reading index 1 returns it.
- R2: `irq_out[31]` is high exactly when (raw level AND enable mask) is nonzero. It reflects an input change or an enable write at the clock edge where that change is captured.
- R3: Read data for each index: 0 gives level AND enable; 1 gives the raw level; 2 gives the enable mask; 4 gives raw level bit 0 in bit 0, with zeros elsewhere; 8 gives the routing mask. The data arrives with `rsp_valid` high in the cycle after the accepted read, and `req_ready` is always 1.
- R4: A write to index 2 ORs the data into the enable mask. A write to index 3 clears every enable bit that is set in the data.
- R5: A write to index 4 with nonzero data sets enable bit 0, and a write to index 5 with nonzero data clears it. Writing zero to either index changes nothing.
- R6: A write to index 8 ORs (data AND 32'h7FE00000) into the routing mask, so only bits 21 to 30 can ever be set. A write to index 9 clears the routing bits that are set in the data.
- R7: While a routing bit is set, the output line of that index equals the raw level bit. Setting the routing bit refreshes the line from the input level at the same edge.
- R8: An output line in the window whose routing bit is clear keeps its last value. Lines 0 to 20 are always low.
- R9: A read of any other index returns 0. A write to any other index, including 0 and 1, leaves both masks unchanged.
- R10: A synchronous reset (`rst` high) clears the level, enable and routing registers and drives every output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 32 | Level-sensitive interrupt requests |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request ready, always 1 |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Byte address; bits 11:2 select the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read is accepted |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | 32 | Routed lines 21 to 30, combined line at 31, others low |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. This covers the level capture, the combined line after an input or enable change, the routed lines after an input or routing-mask change, and the read response. A read returns the register state from before the edge that accepts it, so a write and a following read are separated by one cycle. The bench drives stimulus just after a rising edge. It stamps each expected output and response with the edge count at which it falls due, and the monitor compares on the falling edge once that count is reached. The checks cover ignored writes, zero-valued writes to the bit-0 indices, and address bits outside the window. In each case the bench reads the affected mask back, or watches the output it could have moved.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  // register window: 4 KB, word indexed
  localparam int unsigned WIN_BITS = 12;
  localparam int unsigned IDX_W    = WIN_BITS - 2;

  typedef logic [IDX_W-1:0] reg_idx_t;

  localparam reg_idx_t IX_MASKED = reg_idx_t'(0);
  localparam reg_idx_t IX_RAW    = reg_idx_t'(1);
  localparam reg_idx_t IX_EN_SET = reg_idx_t'(2);
  localparam reg_idx_t IX_EN_CLR = reg_idx_t'(3);
  localparam reg_idx_t IX_B0_SET = reg_idx_t'(4);
  localparam reg_idx_t IX_B0_CLR = reg_idx_t'(5);
  localparam reg_idx_t IX_PT_SET = reg_idx_t'(8);
  localparam reg_idx_t IX_PT_CLR = reg_idx_t'(9);
endpackage

// File: rtl/irqx_csr.sv
module irqx_csr
  import irqx_pkg::*;
#(
  parameter int unsigned N_IRQ = 32,
  parameter int unsigned PT_LO = 21,
  parameter int unsigned PT_HI = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             wr,
  input  reg_idx_t         idx,
  input  logic [N_IRQ-1:0] wdata,
  input  logic [N_IRQ-1:0] level,
  output logic [N_IRQ-1:0] en_q,
  output logic [N_IRQ-1:0] pt_q,
  output logic [N_IRQ-1:0] pt_nxt,
  output logic             rsp_valid,
  output logic [N_IRQ-1:0] rsp_data
);
  function automatic logic [N_IRQ-1:0] window_mask();
    logic [N_IRQ-1:0] m;
    m = '0;
    for (int i = PT_LO; i <= PT_HI; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [N_IRQ-1:0] PT_MASK = window_mask();

  logic [N_IRQ-1:0] en_nxt;
  logic [N_IRQ-1:0] rd_mux;
  logic             known_wr;

  // write decode: set / clear semantics
  always_comb begin
    en_nxt   = en_q;
    pt_nxt   = pt_q;
    known_wr = 1'b1;
    case (idx)
      IX_EN_SET: en_nxt = en_q | wdata;
      IX_EN_CLR: en_nxt = en_q & ~wdata;
      IX_B0_SET: if (|wdata) en_nxt[0] = 1'b1;
      IX_B0_CLR: if (|wdata) en_nxt[0] = 1'b0;
      IX_PT_SET: pt_nxt = pt_q | (wdata & PT_MASK);
      IX_PT_CLR: pt_nxt = pt_q & ~wdata;
      default:   known_wr = 1'b0;
    endcase
    if (!(acc && wr)) begin
      en_nxt = en_q;
      pt_nxt = pt_q;
    end
  end

  // read mux on pre-edge state
  always_comb begin
    case (idx)
      IX_MASKED: rd_mux = level & en_q;
      IX_RAW:    rd_mux = level;
      IX_EN_SET: rd_mux = en_q;
      IX_B0_SET: rd_mux = {{(N_IRQ-1){1'b0}}, level[0]};
      IX_PT_SET: rd_mux = pt_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      pt_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      en_q      <= en_nxt;
      pt_q      <= pt_nxt;
      rsp_valid <= acc && !wr;
      rsp_data  <= (acc && !wr) ? rd_mux : '0;
    end
  end

  // R4
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && wr && idx == IX_EN_CLR) |=> ((en_q & $past(wdata)) == '0));

  // R6
  pt_window_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && wr && idx == IX_PT_SET) |=> ((pt_q & ~PT_MASK) == ($past(pt_q) & ~PT_MASK)));

  // R9
  undef_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && wr && !known_wr) |=> ($stable(en_q) && $stable(pt_q)));

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !wr) |=> rsp_valid);
endmodule

// File: rtl/irqx_route.sv
module irqx_route #(
  parameter int unsigned N_IRQ = 32,
  parameter int unsigned PT_LO = 21,
  parameter int unsigned PT_HI = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [N_IRQ-1:0] pt_nxt,
  output logic [N_IRQ-1:0] level_q,
  output logic [N_IRQ-2:0] line
);
  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= irq_in;
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    if (i >= PT_LO && i <= PT_HI) begin : g_pt
      logic q;
      // routed line follows the input while its routing bit is set
      always_ff @(posedge clk) begin
        if (rst)            q <= 1'b0;
        else if (pt_nxt[i]) q <= irq_in[i];
      end
      assign line[i] = q;

      // R8
      pt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pt_nxt[i] |=> $stable(q));
    end else begin : g_off
      if (i < N_IRQ - 1) begin : g_tie
        assign line[i] = 1'b0;
      end
      // R6
      pt_outside_chk: assert property (@(posedge clk) disable iff (rst)
        !pt_nxt[i]);
    end
  end
endmodule

// File: rtl/irqx_ctrl.sv
module irqx_ctrl
  import irqx_pkg::*;
#(
  parameter int unsigned N_IRQ  = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PT_LO  = 21,
  parameter int unsigned PT_HI  = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [N_IRQ-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [N_IRQ-1:0]  rsp_rdata,
  output logic [N_IRQ-1:0]  irq_out
);
  localparam int unsigned COMB = N_IRQ - 1;

  reg_idx_t         idx;
  logic [N_IRQ-1:0] level_q;
  logic [N_IRQ-1:0] en_q;
  logic [N_IRQ-1:0] pt_q;
  logic [N_IRQ-1:0] pt_nxt;
  logic [N_IRQ-2:0] line;
  logic             unused_addr;

  assign req_ready   = 1'b1;
  assign idx         = req_addr[WIN_BITS-1:2];
  assign unused_addr = ^{req_addr[ADDR_W-1:WIN_BITS], req_addr[1:0]};

  irqx_csr #(.N_IRQ(N_IRQ), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_csr (
    .clk       (clk),
    .rst       (rst),
    .acc       (req_valid),
    .wr        (req_write),
    .idx       (idx),
    .wdata     (req_wdata),
    .level     (level_q),
    .en_q      (en_q),
    .pt_q      (pt_q),
    .pt_nxt    (pt_nxt),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_rdata)
  );

  irqx_route #(.N_IRQ(N_IRQ), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_route (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .pt_nxt  (pt_nxt),
    .level_q (level_q),
    .line    (line)
  );

  assign irq_out = {|(level_q & en_q), line};

  // R7
  pt_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ((pt_q & (irq_out ^ level_q)) == '0));

  // R2
  comb_en_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && idx == IX_EN_SET && |(req_wdata & irq_in)) |=> irq_out[COMB]);
endmodule

// File: tb/test_irqx_ctrl.sv
`timescale 1ns/1ps
module test_irqx_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] irq_out;

  always #2 clk = ~clk;

  irqx_ctrl i_irqx_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_out(irq_out)
  );

  typedef struct {
    int          due;
    bit          is_rsp;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t    sb_q[$];
  sb_item_t    cur;
  int          cyc = 0;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          finished = 0;
  logic [31:0] m_lvl = '0, m_en = '0, m_pt = '0, m_out = '0;

  localparam int OP_IDLE = 0, OP_RD = 1, OP_WR = 2;

  always @(posedge clk) cyc = cyc + 1;

  // monitor: compare due items on the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      cur = sb_q.pop_front();
      n_checks++;
      if (cur.is_rsp) begin
        if (rsp_valid !== 1'b1 || rsp_rdata !== cur.exp) begin
          n_errors++;
          $display("FAIL %s: rsp valid=%0b data=%h expected valid=1 data=%h",
                   cur.tag, rsp_valid, rsp_rdata, cur.exp);
        end
      end else if (irq_out !== cur.exp) begin
        n_errors++;
        $display("FAIL %s: irq_out=%h expected %h", cur.tag, irq_out, cur.exp);
      end
    end
  end

  task automatic push(input bit is_rsp, input logic [31:0] exp, input string tag);
    sb_item_t it;
    it.due = cyc + 1; it.is_rsp = is_rsp; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // driver: one stimulus per cycle, expected results from the requirements
  task automatic step(input logic [31:0] irq, input int op, input logic [31:0] addr,
                      input logic [31:0] wd, input string tag);
    logic [31:0] rd, ne, np;
    logic [9:0]  ix;
    @(posedge clk); #1;
    irq_in = irq; req_valid = (op != OP_IDLE); req_write = (op == OP_WR);
    req_addr = addr; req_wdata = wd;
    ix = addr[11:2]; ne = m_en; np = m_pt; rd = '0;
    if (op == OP_RD) begin
      case (ix)
        10'd0: rd = m_lvl & m_en;
        10'd1: rd = m_lvl;
        10'd2: rd = m_en;
        10'd4: rd = {31'b0, m_lvl[0]};
        10'd8: rd = m_pt;
        default: rd = '0;
      endcase
    end
    if (op == OP_WR) begin
      case (ix)
        10'd2: ne = ne | wd;
        10'd3: ne = ne & ~wd;
        10'd4: if (wd != 0) ne[0] = 1'b1;
        10'd5: if (wd != 0) ne[0] = 1'b0;
        10'd8: np = np | (wd & 32'h7FE0_0000);
        10'd9: np = np & ~wd;
        default: ;
      endcase
    end
    for (int i = 21; i <= 30; i++) if (np[i]) m_out[i] = irq[i];
    m_out[31] = |(irq & ne);
    m_lvl = irq; m_en = ne; m_pt = np;
    push(1'b0, m_out, tag);
    if (op == OP_RD) push(1'b1, rd, tag);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; req_valid = 1'b0; irq_in = '0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 1'b0;
    m_lvl = '0; m_en = '0; m_pt = '0; m_out = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R10 reset state
    step(32'h0, OP_RD, 32'h4, 0, "R10 reset raw");
    step(32'h0, OP_RD, 32'h8, 0, "R10 reset enable");
    // R1 level capture
    step(32'h8000_0011, OP_IDLE, 0, 0, "R1 capture");
    step(32'h8000_0011, OP_RD, 32'h4, 0, "R1 raw read");
    // R4 / R2 enable set drives combined line
    step(32'h8000_0011, OP_WR, 32'h8, 32'h10, "R4 enable set");
    step(32'h8000_0011, OP_RD, 32'h0, 0, "R3 masked read");
    step(32'h8000_0001, OP_IDLE, 0, 0, "R2 input drop");
    step(32'h8000_0011, OP_IDLE, 0, 0, "R2 input rise");
    // R5 bit-0 set / clear
    step(32'h8000_0001, OP_WR, 32'h10, 32'h0, "R5 zero set ignored");
    step(32'h8000_0001, OP_RD, 32'h8, 0, "R5 enable after zero set");
    step(32'h8000_0001, OP_WR, 32'h10, 32'h100, "R5 bit0 set");
    step(32'h8000_0001, OP_RD, 32'h10, 0, "R3 level bit0 read");
    step(32'h8000_0001, OP_RD, 32'h8, 0, "R3 enable read");
    step(32'h8000_0001, OP_WR, 32'h14, 32'h0, "R5 zero clear ignored");
    step(32'h8000_0001, OP_WR, 32'h14, 32'h5, "R5 bit0 clear");
    step(32'h8000_0001, OP_WR, 32'hC, 32'h10, "R4 enable clear");
    step(32'h8000_0001, OP_RD, 32'h8, 0, "R4 enable after clear");
    // R6 routing mask
    step(32'h8000_0001, OP_WR, 32'h20, 32'hFFFF_FFFF, "R6 route set");
    step(32'h8000_0001, OP_RD, 32'h20, 0, "R6 route window");
    // R7 routed lines follow inputs
    step(32'h0060_0000, OP_IDLE, 0, 0, "R7 follow 21/22");
    step(32'h4020_0000, OP_IDLE, 0, 0, "R7 follow 21/30");
    // R8 hold after clearing routing bit 21
    step(32'h4020_0000, OP_WR, 32'h24, 32'h0020_0000, "R6 route clear");
    step(32'h0000_0000, OP_IDLE, 0, 0, "R8 line21 holds");
    step(32'h0000_0000, OP_RD, 32'h20, 0, "R6 route after clear");
    // R7 refresh on set
    step(32'h0000_0000, OP_WR, 32'h20, 32'h0020_0000, "R7 refresh on set");
    // R8 low lines never driven
    step(32'h001F_FFFF, OP_IDLE, 0, 0, "R8 low lines");
    // R9 undefined indices and ignored address bits
    step(32'h0000_0003, OP_RD, 32'h18, 0, "R9 undefined read");
    step(32'h0000_0003, OP_RD, 32'hFFC, 0, "R9 top read");
    step(32'h0000_0003, OP_WR, 32'h18, 32'hFFFF_FFFF, "R9 undefined write");
    step(32'h0000_0003, OP_WR, 32'h0, 32'hFFFF_FFFF, "R9 write idx0");
    step(32'h0000_0003, OP_WR, 32'h24 + 32'h3C, 32'hFFFF_FFFF, "R9 write idx24");
    step(32'h0000_0003, OP_RD, 32'h8, 0, "R9 enable unchanged");
    step(32'h0000_0003, OP_RD, 32'h20, 0, "R9 route unchanged");
    step(32'h0000_0003, OP_WR, 32'h1000_0008, 32'h2, "R9 high addr bits");
    step(32'h0000_0003, OP_RD, 32'hABC0_0004, 0, "R9 high addr read");
    // R10 mid-run reset
    step(32'h4000_0002, OP_WR, 32'h8, 32'hFFFF_FFFF, "R2 all enabled");
    do_reset();
    step(32'h0, OP_RD, 32'h8, 0, "R10 enable cleared");
    step(32'h0, OP_RD, 32'h20, 0, "R10 route cleared");
    step(32'h0040_0000, OP_IDLE, 0, 0, "R10 no routing");
    step(32'h0, OP_IDLE, 0, 0, "R10 idle");
    repeat (3) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule